// File: doc/BRIEF.md
# Chip-Select Quiet-Window Checker

This block is a synchronous protocol monitor for a pair of field memories that share write, read and control lines and take turns through a single chip-select line. All of its inputs are sampled on one checker clock, including the memories' write clock and read clock. It watches every change of chip select. Around each change it checks three things: the four enables must have been quiet for long enough, neither pointer-reset strobe may be active, and the enables must stay low for a short period afterwards. It also checks that each chip-select level lasts at least a minimum number of cycles.

A polarity strap sets which level of chip select enables the memory. Each rule has its own bit in a sticky error code, and a single violation flag summarises the code. Only a synchronous reset clears them. Each rule's window (clock edges, hold cycles, enabled and disabled widths) is a parameter counted in checker-clock cycles, so the block can be scaled to any checker clock.

Top module: `cs_quiet_checker`

## Requirements
- R1: While `rst` is high at a clock edge, `err_code` is cleared to 0 and `viol` to 0. Nothing else clears them.
- R2: Consider a cycle in which `cs` differs from its value in the previous cycle (a change cycle). Count the rising edges of `wclk` and of `rclk` seen on earlier cycles while `we`, `ie`, `re` and `oe` were all low. If either count is below `MIN_EDGES`, or if any enable is high in the change cycle, bit 0 (value 1) is set.
- R3: Any enable seen high restarts both quiet-edge counts from zero.
- R4: If `rst_w` or `rst_r` is high in a change cycle, bit 1 (value 2) is set.
- R5: If any enable is high in any of the `HOLD_CYC` cycles after a change cycle, bit 2 (value 4) is set. An enable that first rises on cycle `HOLD_CYC`+1 sets nothing.
- R6: If chip select leaves the enabling level after holding it for fewer than `MIN_EN_CYC` cycles, bit 3 (value 8) is set. The level that holds up to the first change after reset is not checked.
- R7: If chip select leaves the disabling level after holding it for fewer than `MIN_DIS_CYC` cycles, bit 4 (value 16) is set. The first level after reset is not checked, as in R6.
- R8: With `cs_pol` = 0, chip select high is the enabling level. With `cs_pol` = 1, chip select low is the enabling level.
- R9: Error bits are sticky, and several rules can set several bits at once. `viol` is high exactly when any bit of `err_code` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Checker clock |
| rst | input | 1 | Synchronous reset, active high |
| wclk | input | 1 | Memory write clock, sampled as data |
| rclk | input | 1 | Memory read clock, sampled as data |
| cs | input | 1 | Shared chip select |
| cs_pol | input | 1 | Polarity strap: 0 means high enables, 1 means low enables |
| we | input | 1 | Write enable |
| ie | input | 1 | Input (write mask) enable |
| re | input | 1 | Read enable |
| oe | input | 1 | Output enable |
| rst_w | input | 1 | Write pointer reset strobe |
| rst_r | input | 1 | Read pointer reset strobe |
| viol | output | 1 | Sticky: any rule has been broken |
| err_code | output | 5 | Sticky per-rule error bits, see R2 to R7 |

## Verification
The bench builds the checker with `MIN_EDGES` = 5, `HOLD_CYC` = 3, `MIN_EN_CYC` = 12 and `MIN_DIS_CYC` = 8. These short windows let each boundary be hit exactly: four against five quiet edges, an enable on hold cycle three against cycle four, and seven against eight disabled cycles or eleven against twelve enabled ones. Because the enabled and disabled minimums differ, the same chip-select sequence gives a different error bit under each setting of the polarity strap, which brings the strap itself under test.

// File: rtl/cs_quiet_checker.sv
module cs_quiet_checker #(
  parameter int MIN_EDGES   = 5,
  parameter int HOLD_CYC    = 3,
  parameter int MIN_EN_CYC  = 420,
  parameter int MIN_DIS_CYC = 420
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wclk,
  input  logic       rclk,
  input  logic       cs,
  input  logic       cs_pol,
  input  logic       we,
  input  logic       ie,
  input  logic       re,
  input  logic       oe,
  input  logic       rst_w,
  input  logic       rst_r,
  output logic       viol,
  output logic [4:0] err_code
);
  localparam int EW   = $clog2(MIN_EDGES + 2);
  localparam int HW   = $clog2(HOLD_CYC + 2);
  localparam int LMAX = (MIN_EN_CYC > MIN_DIS_CYC) ? MIN_EN_CYC : MIN_DIS_CYC;
  localparam int LW   = $clog2(LMAX + 2);

  logic          cs_q, wclk_q, rclk_q, armed;
  logic [EW-1:0] wcnt, rcnt;
  logic [HW-1:0] hcnt;
  logic [LW-1:0] lvl_cnt;
  logic [4:0]    err_q, err_new;

  wire en_any  = we | ie | re | oe;
  wire cs_chg  = cs ^ cs_q;
  wire w_rise  = wclk & ~wclk_q;
  wire r_rise  = rclk & ~rclk_q;
  wire prev_en = cs_q ^ cs_pol;
  wire quiet_short = (wcnt < EW'(MIN_EDGES)) | (rcnt < EW'(MIN_EDGES));

  always_comb begin
    err_new[0] = cs_chg & (quiet_short | en_any);
    err_new[1] = cs_chg & (rst_w | rst_r);
    err_new[2] = (hcnt != '0) & en_any;
    err_new[3] = cs_chg & armed &  prev_en & (lvl_cnt < LW'(MIN_EN_CYC));
    err_new[4] = cs_chg & armed & ~prev_en & (lvl_cnt < LW'(MIN_DIS_CYC));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= cs;
      wclk_q  <= wclk;
      rclk_q  <= rclk;
      wcnt    <= '0;
      rcnt    <= '0;
      hcnt    <= '0;
      lvl_cnt <= '0;
      armed   <= 1'b0;
      err_q   <= '0;
    end else begin
      cs_q   <= cs;
      wclk_q <= wclk;
      rclk_q <= rclk;
      err_q  <= err_q | err_new;

      if (en_any)                                  wcnt <= '0;
      else if (w_rise && wcnt < EW'(MIN_EDGES))    wcnt <= wcnt + 1'b1;
      if (en_any)                                  rcnt <= '0;
      else if (r_rise && rcnt < EW'(MIN_EDGES))    rcnt <= rcnt + 1'b1;

      if (cs_chg)             hcnt <= HW'(HOLD_CYC);
      else if (hcnt != '0)    hcnt <= hcnt - 1'b1;

      if (cs_chg) begin
        lvl_cnt <= LW'(1);
        armed   <= 1'b1;
      end else if (lvl_cnt < LW'(LMAX)) begin
        lvl_cnt <= lvl_cnt + 1'b1;
      end
    end
  end

  assign err_code = err_q;
  assign viol     = |err_q;
endmodule

// File: rtl/cs_quiet_checker_sva.sv
module cs_quiet_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       we,
  input logic       ie,
  input logic       re,
  input logic       oe,
  input logic       rst_w,
  input logic       rst_r,
  input logic [4:0] err_code
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> err_code == 5'd0)
    else $error("reset did not clear error code");

  p_quiet_enable_r2: assert property (@(posedge clk) disable iff (rst)
    (cs != $past(cs)) && (we | ie | re | oe) |=> err_code[0])
    else $error("enable high at chip-select change not flagged");

  p_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (cs != $past(cs)) && (rst_w | rst_r) |=> err_code[1])
    else $error("reset strobe at chip-select change not flagged");

  p_hold_first_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(cs) != $past(cs, 2)) && (we | ie | re | oe) |=> err_code[2])
    else $error("enable right after chip-select change not flagged");

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((err_code & $past(err_code)) == $past(err_code)))
    else $error("error bit dropped without reset");
endmodule

bind cs_quiet_checker cs_quiet_checker_sva u_sva (.*);

// File: tb/cs_quiet_checker_tb.sv
module cs_quiet_checker_tb_top;
  localparam int MIN_EDGES = 5, HOLD_CYC = 3, MIN_EN = 12, MIN_DIS = 8;

  logic clk = 1'b0;
  logic rst, wclk, rclk, cs, cs_pol, we, ie, re, oe, rst_w, rst_r;
  logic viol;
  logic [4:0] err_code;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cs_quiet_checker #(.MIN_EDGES(MIN_EDGES), .HOLD_CYC(HOLD_CYC),
                     .MIN_EN_CYC(MIN_EN), .MIN_DIS_CYC(MIN_DIS)) dut_i (
    .clk(clk), .rst(rst), .wclk(wclk), .rclk(rclk), .cs(cs), .cs_pol(cs_pol),
    .we(we), .ie(ie), .re(re), .oe(oe), .rst_w(rst_w), .rst_r(rst_r),
    .viol(viol), .err_code(err_code));

  // {nw[4], nr[4], sw, sr, keep, gd[3], blip, nb[4], exp[5]}
  localparam logic [23:0] VEC [0:11] = '{
    {4'd5, 4'd5, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd0, 5'd0},   // R2 clean
    {4'd4, 4'd5, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd0, 5'd1},   // R2 wclk short
    {4'd5, 4'd4, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd0, 5'd1},   // R2 rclk short
    {4'd6, 4'd9, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 4'd0, 5'd2},   // R4 write strobe
    {4'd6, 4'd6, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd0, 5'd2},   // R4 read strobe
    {4'd5, 4'd5, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 4'd0, 5'd4},   // R5 first hold cycle
    {4'd5, 4'd5, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 4'd0, 5'd4},   // R5 last hold cycle
    {4'd5, 4'd5, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 4'd0, 5'd0},   // R5 past hold
    {4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 4'd0, 5'd7},   // R9 multi-bit
    {4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd0, 5'd5},   // R2 enables held
    {4'd5, 4'd5, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd3, 5'd1},   // R3 restart short
    {4'd5, 4'd5, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd5, 5'd0}    // R3 restart enough
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input logic [4:0] exp, input string tag);
    checks++;
    if (err_code !== exp || viol !== (exp != 5'd0)) begin
      errors++;
      $display("FAIL %s: err_code=%0d viol=%0b expected err_code=%0d viol=%0b",
               tag, err_code, viol, exp, exp != 5'd0);
    end
  endtask

  task automatic do_reset(input logic pol, input logic cs0, input logic en);
    rst = 1'b1; cs_pol = pol; cs = cs0;
    we = en; ie = en; re = en; oe = en;
    wclk = 1'b0; rclk = 1'b0; rst_w = 1'b0; rst_r = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(2);
  endtask

  task automatic pulses(input int nw, input int nr);
    for (int i = 0; i < ((nw > nr) ? nw : nr); i++) begin
      wclk = (i < nw); rclk = (i < nr);
      tick(1);
      wclk = 1'b0; rclk = 1'b0;
      tick(1);
    end
  endtask

  task automatic run_vec(input logic [23:0] v, input int idx);
    logic keep;
    int gd;
    keep = v[13];
    gd = int'(v[12:10]);
    do_reset(1'b0, 1'b1, 1'b1);
    if (!keep) begin
      we = 0; ie = 0; re = 0; oe = 0;
    end
    tick(1);
    pulses(int'(v[23:20]), int'(v[19:16]));
    if (v[9]) begin
      oe = 1'b1; tick(1); oe = 1'b0; tick(1);
      pulses(int'(v[8:5]), int'(v[8:5]));
    end
    cs = ~cs; rst_w = v[15]; rst_r = v[14];
    for (int j = 1; j <= 7; j++) begin
      tick(1);
      rst_w = 1'b0; rst_r = 1'b0;
      we = keep | (gd != 0 && j == gd);
      ie = keep; re = keep; oe = keep;
    end
    tick(2);
    check(v[4:0], $sformatf("vector %0d (R2 R3 R4 R5 R9)", idx));
  endtask

  task automatic pulse_run(input logic pol, input logic cs0, input int len,
                           input logic [4:0] exp, input string tag);
    do_reset(pol, cs0, 1'b0);
    pulses(6, 6);
    cs = ~cs;
    tick(len);
    cs = ~cs;
    tick(4);
    check(exp, tag);
  endtask

  initial begin
    do_reset(1'b0, 1'b1, 1'b0);
    check(5'd0, "R1 reset state");

    for (int i = 0; i < 12; i++) run_vec(VEC[i], i);

    pulse_run(1'b0, 1'b1, 7,  5'd16, "R7 disabled level 7 cycles");
    pulse_run(1'b0, 1'b1, 8,  5'd0,  "R7 disabled level 8 cycles");
    pulse_run(1'b0, 1'b0, 11, 5'd8,  "R6 R8 enabled high 11 cycles");
    pulse_run(1'b0, 1'b0, 12, 5'd0,  "R6 enabled level 12 cycles");
    pulse_run(1'b1, 1'b0, 11, 5'd0,  "R8 high is disabled when strap set");
    pulse_run(1'b1, 1'b1, 7,  5'd8,  "R8 low is enabled when strap set");

    tick(20);
    check(5'd8, "R9 bit stays set");
    rst = 1'b1; tick(2); rst = 1'b0; tick(1);
    check(5'd0, "R1 reset clears sticky bits");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule